// File: doc/BRIEF.md
# Accumulator-Addressed Output Port Selector

This block sits between the instruction sequencer of a small 12-bit processor and its output devices. When the sequencer executes an output operation, the block takes the 12-bit accumulator value and uses its upper bits to pick the device. The remaining lower bits become the data for that device. The block drives four 8-bit byte ports and three 10-bit converter channels. Byte port 0 is the serial terminal transmitter. An accumulator whose top four bits are zero addresses the terminal, so older code that writes plain characters keeps working unchanged.

There are two output operations. The character operation waits for the terminal transmitter to go idle. While it waits, the block raises a stall to the sequencer and holds the value it captured. The raw operation writes at once and never looks at any readiness flag, so software must handle any flow control. Each write shows up as a single-clock strobe on exactly one device, with the data presented on a shared bus for that device class.

Top module: `acc_out_router`

## Requirements
- R1: While reset is asserted and right after it, every write strobe is low, stall is low, and both data buses are zero.
- R2: When accumulator bits [11:10] hold a nonzero value k, the write targets converter channel k. The strobe is dac_we bit k-1, and dac_data carries accumulator bits [9:0].
- R3: When accumulator bits [11:10] are 00, bits [9:8] pick byte port d and the strobe is byte_we bit d. byte_data carries accumulator bits [7:0]. Port 0 is the terminal.
- R4: A raw-output strobe produces its device write on the next clock edge, whatever the level of tx_busy. Stall stays low.
- R5: A character strobe with tx_busy low produces its write on the next clock edge. Stall stays low.
- R6: A character strobe with tx_busy high raises stall in that cycle and in every later cycle in which tx_busy stays high. No strobe fires during the wait. The accumulator value seen with the strobe is written on the edge that ends the first cycle in which tx_busy is low.
- R7: At most one write strobe is high in any cycle, and a single operation gives a pulse exactly one clock long.
- R8: Strobes presented while a character write is waiting, including its release cycle, are ignored. They produce no write and do not alter the captured value.
- R9: If both strobes arrive in the same cycle, the character operation is taken and the raw one is dropped.
- R10: A data bus keeps its last written value until the next write to a device of its own class.
- R11: A character operation with nonzero upper bits still waits for tx_busy low, then writes to the decoded device rather than the terminal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc | input | 12 | Accumulator value to route |
| put_char | input | 1 | Character-output strobe, waits for transmitter idle |
| put_raw | input | 1 | Raw-output strobe, writes without a readiness check |
| tx_busy | input | 1 | Terminal transmitter busy flag |
| stall | output | 1 | Holds the sequencer while a character write waits |
| byte_we | output | 4 | Per-port write strobes for the 8-bit devices |
| byte_data | output | 8 | Data for the 8-bit devices |
| dac_we | output | 3 | Per-channel write strobes for the converters |
| dac_data | output | 10 | Data for the converter channels |

## Verification
The assertions check, on every cycle, that at most one strobe is high and that a stalled cycle is never followed by a write. They also check that an accepted raw or character strobe yields exactly one write on the next edge, and that a raw write carries the accumulator bits from the cycle before. Some behaviour only the bench scenarios can show. These are the full address decode across all 4096 accumulator values, and that the captured value survives interfering strobes and a changing accumulator during a wait. The bench also covers the PUTC-over-OUTPUT priority, data-bus hold between writes, and the misuse case of a character write aimed at a non-terminal device.

// File: rtl/acc_out_pkg.sv
// Package: shared types for the accumulator output selector.
// Assumes a two-state character-write controller.
package acc_out_pkg;

    typedef enum logic [0:0] {
        PC_IDLE = 1'b0,
        PC_WAIT = 1'b1
    } putc_state_e;

endpackage

// File: rtl/acc_out_decode.sv
// Module: acc_out_decode
// Turns an accumulator value into one-hot device selects.
// A nonzero upper field picks a converter channel. Otherwise the next field
// picks a byte port. Purely combinational; assumes DAC_W > BYTE_W.
module acc_out_decode #(
    parameter int ACC_W  = 12,
    parameter int DAC_W  = 10,
    parameter int BYTE_W = 8,
    localparam int SEL_W  = ACC_W - DAC_W,
    localparam int PRT_W  = DAC_W - BYTE_W,
    localparam int N_DAC  = (1 << SEL_W) - 1,
    localparam int N_BYTE = 1 << PRT_W
) (
    input  logic [ACC_W-1:0]  acc_val,
    output logic [N_BYTE-1:0] byte_sel,
    output logic [N_DAC-1:0]  dac_sel
);

    logic [SEL_W-1:0] hi_field;
    logic [PRT_W-1:0] port_field;

    assign hi_field   = acc_val[ACC_W-1:DAC_W];
    assign port_field = acc_val[DAC_W-1:BYTE_W];

    // One compare per converter channel; channel k answers to field value k+1
    for (genvar k = 0; k < N_DAC; k++) begin : g_dac
        assign dac_sel[k] = (hi_field == SEL_W'(k + 1));
    end

    // One compare per byte port; active only when the upper field is zero
    for (genvar d = 0; d < N_BYTE; d++) begin : g_byte
        assign byte_sel[d] = (hi_field == '0) && (port_field == PRT_W'(d));
    end

endmodule

// File: rtl/acc_out_putc_ctl.sv
// Module: acc_out_putc_ctl
// Accepts the two output strobes and decides when a write issues.
// A raw strobe issues at once. A character strobe issues at once if the
// transmitter is idle. Otherwise the value is captured and the block waits,
// with stall high. Character wins when both strobes coincide. Strobes
// arriving during a wait are ignored.
module acc_out_putc_ctl #(
    parameter int ACC_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             put_char,
    input  logic             put_raw,
    input  logic             tx_busy,
    output logic             issue,
    output logic [ACC_W-1:0] issue_acc,
    output logic             stall
);
    import acc_out_pkg::*;

    putc_state_e      state_q, state_d;
    logic [ACC_W-1:0] held_q, held_d;

    // Next-state, issue and stall decisions
    always_comb begin
        state_d   = state_q;
        held_d    = held_q;
        issue     = 1'b0;
        issue_acc = acc_in;
        stall     = 1'b0;
        case (state_q)
            PC_IDLE: begin
                if (put_char) begin
                    if (tx_busy) begin
                        stall   = 1'b1;
                        held_d  = acc_in;
                        state_d = PC_WAIT;
                    end else begin
                        issue = 1'b1;
                    end
                end else if (put_raw) begin
                    issue = 1'b1;
                end
            end
            PC_WAIT: begin
                issue_acc = held_q;
                if (tx_busy) begin
                    stall = 1'b1;
                end else begin
                    issue   = 1'b1;
                    state_d = PC_IDLE;
                end
            end
            default: state_d = PC_IDLE;
        endcase
    end

    // State and captured-value registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PC_IDLE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

endmodule

// File: rtl/acc_out_router.sv
// Module: acc_out_router (top)
// Routes accumulator writes to byte ports or converter channels.
// Strobes and data are registered, so a write shows one clock after it
// issues. Each data bus holds its value between writes of its class.
module acc_out_router #(
    parameter int ACC_W  = 12,
    parameter int DAC_W  = 10,
    parameter int BYTE_W = 8,
    localparam int N_DAC  = (1 << (ACC_W - DAC_W)) - 1,
    localparam int N_BYTE = 1 << (DAC_W - BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ACC_W-1:0]  acc,
    input  logic              put_char,
    input  logic              put_raw,
    input  logic              tx_busy,
    output logic              stall,
    output logic [N_BYTE-1:0] byte_we,
    output logic [BYTE_W-1:0] byte_data,
    output logic [N_DAC-1:0]  dac_we,
    output logic [DAC_W-1:0]  dac_data
);

    logic              issue;
    logic [ACC_W-1:0]  issue_acc;
    logic [N_BYTE-1:0] byte_sel;
    logic [N_DAC-1:0]  dac_sel;

    acc_out_putc_ctl #(.ACC_W(ACC_W)) u_ctl (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_in    (acc),
        .put_char  (put_char),
        .put_raw   (put_raw),
        .tx_busy   (tx_busy),
        .issue     (issue),
        .issue_acc (issue_acc),
        .stall     (stall)
    );

    acc_out_decode #(.ACC_W(ACC_W), .DAC_W(DAC_W), .BYTE_W(BYTE_W)) u_dec (
        .acc_val  (issue_acc),
        .byte_sel (byte_sel),
        .dac_sel  (dac_sel)
    );

    // Register strobes for one cycle and load the bus of the chosen class
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_we   <= '0;
            dac_we    <= '0;
            byte_data <= '0;
            dac_data  <= '0;
        end else begin
            byte_we <= issue ? byte_sel : '0;
            dac_we  <= issue ? dac_sel  : '0;
            if (issue && (|byte_sel)) byte_data <= issue_acc[BYTE_W-1:0];
            if (issue && (|dac_sel))  dac_data  <= issue_acc[DAC_W-1:0];
        end
    end

endmodule

// File: rtl/acc_out_router_chk.sv
// Module: acc_out_router_chk
// Port-level temporal checks for acc_out_router, attached by bind.
module acc_out_router_chk #(
    parameter int ACC_W  = 12,
    parameter int DAC_W  = 10,
    parameter int BYTE_W = 8,
    localparam int N_DAC  = (1 << (ACC_W - DAC_W)) - 1,
    localparam int N_BYTE = 1 << (DAC_W - BYTE_W)
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ACC_W-1:0]  acc,
    input logic              put_char,
    input logic              put_raw,
    input logic              tx_busy,
    input logic              stall,
    input logic [N_BYTE-1:0] byte_we,
    input logic [N_DAC-1:0]  dac_we,
    input logic [DAC_W-1:0]  dac_data
);

    // R7
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({byte_we, dac_we}) <= 1);

    // R6
    stall_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> ({byte_we, dac_we} == '0));

    // R4
    raw_writes_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put_raw && !put_char && !stall && !$past(stall)) |=> ($countones({byte_we, dac_we}) == 1));

    // R5
    char_idle_writes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put_char && !tx_busy && !$past(stall)) |=> ($countones({byte_we, dac_we}) == 1));

    // R2
    raw_dac_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (put_raw && !put_char && !stall && !$past(stall) && (acc[ACC_W-1:DAC_W] != '0))
            |=> (dac_data == $past(acc[DAC_W-1:0])));

endmodule

bind acc_out_router acc_out_router_chk #(
    .ACC_W(ACC_W), .DAC_W(DAC_W), .BYTE_W(BYTE_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .acc(acc), .put_char(put_char),
    .put_raw(put_raw), .tx_busy(tx_busy), .stall(stall),
    .byte_we(byte_we), .dac_we(dac_we), .dac_data(dac_data)
);

// File: tb/acc_out_router_bench.sv
// Bench: sweeps every accumulator value through the raw path and exercises
// character waits, interfering strobes, priority and misuse.
module acc_out_router_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] acc = '0;
    logic        put_char = 1'b0;
    logic        put_raw = 1'b0;
    logic        tx_busy = 1'b0;
    logic        stall;
    logic [3:0]  byte_we;
    logic [7:0]  byte_data;
    logic [2:0]  dac_we;
    logic [9:0]  dac_data;

    int checks = 0;
    int failures = 0;
    int misuse = 0;
    int cycles = 0;
    logic [7:0] last_byte = '0;
    logic [9:0] last_dac = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_out_router u_acc_out_router (
        .clk(clk), .rst_n(rst_n), .acc(acc), .put_char(put_char),
        .put_raw(put_raw), .tx_busy(tx_busy), .stall(stall),
        .byte_we(byte_we), .byte_data(byte_data),
        .dac_we(dac_we), .dac_data(dac_data)
    );

    // Count one check and report a mismatch
    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Expected strobes from the decode rule of R2 and R3
    function automatic void expect_of(input logic [11:0] a,
                                      output logic [3:0] bw, output logic [2:0] dw);
        bw = '0;
        dw = '0;
        if (a[11:10] != 2'd0) dw = 3'(3'b001 << (a[11:10] - 2'd1));
        else                  bw = 4'(4'b0001 << a[9:8]);
    endfunction

    // Compare a write against value a; also checks bus hold (R10)
    task automatic verify_write(input logic [11:0] a, input string req);
        logic [3:0] bw;
        logic [2:0] dw;
        expect_of(a, bw, dw);
        check(byte_we == bw, req, "byte_we", int'(byte_we), int'(bw));
        check(dac_we == dw, req, "dac_we", int'(dac_we), int'(dw));
        if (dw != 0) begin
            check(dac_data == a[9:0], "R2", "dac_data", int'(dac_data), int'(a[9:0]));
            check(byte_data == last_byte, "R10", "byte_data hold", int'(byte_data), int'(last_byte));
            last_dac = a[9:0];
        end else begin
            check(byte_data == a[7:0], "R3", "byte_data", int'(byte_data), int'(a[7:0]));
            check(dac_data == last_dac, "R10", "dac_data hold", int'(dac_data), int'(last_dac));
            last_byte = a[7:0];
        end
    endtask

    // Raw write (R4): busy level must not matter
    task automatic do_raw(input logic [11:0] a, input logic busy);
        @(negedge clk);
        acc = a; put_raw = 1'b1; tx_busy = busy;
        #(CLK_PERIOD/4);
        check(stall == 1'b0, "R4", "stall on raw", int'(stall), 0);
        @(negedge clk);
        put_raw = 1'b0; tx_busy = 1'b0;
        verify_write(a, "R4");
    endtask

    // Character write with n busy cycles; optional interference and dual strobe
    task automatic do_char(input logic [11:0] a, input int n,
                           input bit interfere, input bit both);
        @(negedge clk);
        acc = a; put_char = 1'b1; put_raw = both; tx_busy = (n > 0);
        if (a[11:8] != 4'd0) misuse++;
        #(CLK_PERIOD/4);
        check(stall == (n > 0), (n > 0) ? "R6" : "R5", "stall at strobe", int'(stall), (n > 0) ? 1 : 0);
        for (int i = 1; i <= n; i++) begin
            @(negedge clk);
            check({byte_we, dac_we} == 7'd0, both ? "R9" : "R6", "strobe while waiting",
                  int'({byte_we, dac_we}), 0);
            put_char = interfere; put_raw = interfere; tx_busy = (i < n);
            if (interfere) acc = ~a;
            #(CLK_PERIOD/4);
            check(stall == (i < n), "R6", "stall during wait", int'(stall), (i < n) ? 1 : 0);
        end
        @(negedge clk);
        put_char = 1'b0; put_raw = 1'b0; tx_busy = 1'b0;
        verify_write(a, interfere ? "R8" : ((n > 0) ? "R6" : "R5"));
        @(negedge clk);
        check({byte_we, dac_we} == 7'd0, interfere ? "R8" : "R7", "no extra strobe",
              int'({byte_we, dac_we}), 0);
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(byte_we == 0 && dac_we == 0, "R1", "strobes in reset", int'({byte_we, dac_we}), 0);
        check(stall == 0, "R1", "stall in reset", int'(stall), 0);
        check(byte_data == 0 && dac_data == 0, "R1", "buses in reset", int'({byte_data, dac_data}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check({byte_we, dac_we} == 0, "R1", "strobes after reset", int'({byte_we, dac_we}), 0);

        // R2, R3, R4: every accumulator value via raw path, busy toggling
        for (int v = 0; v < 4096; v++) do_raw(12'(v), v[0]);

        // R7: single raw write is one clock long
        do_raw(12'h2A5, 1'b0);
        @(negedge clk);
        check({byte_we, dac_we} == 0, "R7", "pulse width", int'({byte_we, dac_we}), 0);

        // R5: character to terminal with idle transmitter
        do_char(12'h041, 0, 1'b0, 1'b0);
        // R6: waits of several lengths
        do_char(12'h05A, 1, 1'b0, 1'b0);
        do_char(12'h033, 4, 1'b0, 1'b0);
        // R8: interfering strobes and changing accumulator during wait
        do_char(12'h07E, 3, 1'b1, 1'b0);
        // R9: both strobes with busy high; character taken
        do_char(12'h062, 2, 1'b0, 1'b1);
        // R9: both strobes with idle transmitter give one write
        do_char(12'h0C8, 0, 1'b0, 1'b1);
        // R11: character misuse to converter and to byte port 2
        do_char(12'hC05, 3, 1'b0, 1'b0);
        do_char(12'h2F1, 2, 1'b0, 1'b0);
        check(misuse == 2, "R11", "legacy misuse count", misuse, 2);
        $display("note: %0d character writes aimed past the terminal (legacy misuse)", misuse);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule